// File: doc/BRIEF.md
# UART Receive/Transmit Line Status Keeper

This block holds the line status word of a UART. Received characters come in already deserialised, each marked with three error tags: parity, framing and break. They go into a receive FIFO. The status word then reports on the character at the head of that FIFO, not on the newest arrival. The block also follows the transmit path through a small state machine that tracks whether the holding register and the shift register hold data.

Software reads the status word with a one-cycle read strobe. The word is returned combinationally in the strobe cycle, and the clear-on-read effects apply from the next cycle. A summary bit reports that at least one errored character is present. It is backed by a count of errored entries, so a read clears it only once no errored character remains. When FIFO mode is off, the receiver behaves as a single holding register that each new character overwrites, and the summary bit reads 0.

The transmit state machine has four states:
- `TX_IDLE`: both registers are empty.
- `TX_HOLD`: only the holding register is full.
- `TX_SHIFT`: only the shift register is busy.
- `TX_BOTH`: both registers are full.

Its transitions are:
- IDLE→HOLD on a holding write.
- HOLD→SHIFT on a load.
- HOLD→BOTH on a load together with a write.
- SHIFT→IDLE on shift done.
- SHIFT→BOTH on a write.
- SHIFT→HOLD on done together with a write.
- BOTH→HOLD on done.
- Every other input combination keeps the current state.

Top module: `uart_lsr_tracker`

## Requirements
- R1: Status word layout is bit0 data-ready, bit1 overrun, bit2 parity error, bit3 framing error, bit4 break, bit5 holding-empty, bit6 transmitter-empty, bit7 FIFO-error summary; after reset it reads 0x60.
- R2: Data-ready is 1 exactly while the receive store is non-empty. `rbr_data` shows the head character. A pop strobe on an empty store is ignored.
- R3: The parity, framing and break bits show the error tags of the head character, not those of later arrivals.
- R4: A status read clears the parity, framing and break bits from the next cycle on, until a different character becomes head.
- R5: Holding-empty is 1 whenever the holding register is empty and goes to 0 in the cycle after a holding write.
- R6: Transmitter-empty is 1 only in `TX_IDLE`; it is 0 if either register holds data.
- R7: The transmit state follows the transitions listed above. A load is honoured only in `TX_HOLD`, and shift done only in `TX_SHIFT` or `TX_BOTH`.
- R8: The summary bit sets when a character carrying any error tag is accepted into the receive store.
- R9: On a status read, the summary bit clears only if no errored characters remain after that cycle; otherwise it stays 1.
- R10: With FIFO mode off, the store holds one character, the summary bit reads 0, and a new character arriving while one is held replaces it and sets overrun.
- R11: In FIFO mode, with 16 entries full, a push without a simultaneous pop is dropped and sets overrun. A status read clears overrun unless a new overrun happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single holding register |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error tag of the character |
| rx_ferr | input | 1 | Framing error tag of the character |
| rx_brk | input | 1 | Break tag of the character |
| rbr_rd | input | 1 | Pop the head character |
| rbr_data | output | 8 | Head character |
| lsr_rd | input | 1 | Status read strobe (clear-on-read) |
| lsr | output | 8 | Status word |
| thr_wr | input | 1 | Software write to the holding register |
| tsr_load | input | 1 | Shift register takes the holding content |
| tsr_done | input | 1 | Shift register finished its character |

## Verification
The assertions assume the following about the inputs:
- `fifo_en` changes only while the receive store is empty.
- In single-register mode, no more than one character is ever held.
- Strobes are one-cycle pulses sampled on the rising edge.

The stimulus changes the mode only after draining the store, drives every strobe for exactly one cycle from the falling edge, and uses load and done strobes only in states where the transmit side can honour them, except where it deliberately checks that such a strobe is ignored.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rx_err_t;

    typedef struct packed {
        rx_err_t            err;
        logic [CHAR_W-1:0]  data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_HOLD  = 2'd1,
        TX_SHIFT = 2'd2,
        TX_BOTH  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
    import lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fifo_en,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      push_acc,
    output logic      pop_acc,
    output logic      overwrite,
    output logic      overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    rx_entry_t       mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count, cap;
    logic            room;

    assign empty     = (count == '0);
    assign cap       = fifo_en ? CW'(DEPTH) : CW'(1);
    assign pop_acc   = pop & ~empty;
    assign room      = (count < cap) | pop_acc;
    assign push_acc  = push & room;
    assign overwrite = push & ~room & ~fifo_en;
    assign overflow  = push & ~room;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (overwrite)
            mem[rd_ptr] <= push_entry;
        else if (push_acc)
            mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_acc)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_acc)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push_acc && !pop_acc)
                count <= count + 1'b1;
            else if (pop_acc && !push_acc)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/lsr_err_track.sv
module lsr_err_track
    import lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fifo_en,
    input  logic    lsr_rd,
    input  logic    empty,
    input  logic    push_acc,
    input  logic    pop_acc,
    input  logic    overwrite,
    input  logic    overflow,
    input  rx_err_t new_err,
    input  rx_err_t head_err,
    output logic    pe,
    output logic    fe,
    output logic    bi,
    output logic    oe,
    output logic    rxfe
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] err_cnt, err_cnt_nx;
    logic          ack, rxfe_q, oe_q;
    logic          new_bad, head_bad, inc, dec, head_change;

    assign new_bad     = new_err.perr | new_err.ferr | new_err.brk;
    assign head_bad    = head_err.perr | head_err.ferr | head_err.brk;
    assign inc         = (push_acc | overwrite) & new_bad;
    assign dec         = (pop_acc | overwrite) & head_bad;
    assign head_change = pop_acc | (push_acc & empty) | overwrite;

    always_comb begin
        err_cnt_nx = err_cnt;
        if (inc && !dec)
            err_cnt_nx = err_cnt + 1'b1;
        else if (dec && !inc)
            err_cnt_nx = err_cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_cnt <= '0;
            ack     <= 1'b0;
            rxfe_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            err_cnt <= err_cnt_nx;
            if (head_change)
                ack <= 1'b0;
            else if (lsr_rd)
                ack <= 1'b1;
            if (inc)
                rxfe_q <= 1'b1;
            else if (lsr_rd)
                rxfe_q <= (err_cnt_nx != '0);
            if (overflow)
                oe_q <= 1'b1;
            else if (lsr_rd)
                oe_q <= 1'b0;
        end
    end

    assign pe   = ~empty & head_err.perr & ~ack;
    assign fe   = ~empty & head_err.ferr & ~ack;
    assign bi   = ~empty & head_err.brk  & ~ack;
    assign oe   = oe_q;
    assign rxfe = fifo_en & rxfe_q;
endmodule

// File: rtl/lsr_tx_fsm.sv
module lsr_tx_fsm
    import lsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thr_wr,
    input  logic tsr_load,
    input  logic tsr_done,
    output logic thre,
    output logic temt
);
    tx_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= TX_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (thr_wr) state_nx = TX_HOLD;
            TX_HOLD:  if (tsr_load) state_nx = thr_wr ? TX_BOTH : TX_SHIFT;
            TX_SHIFT: begin
                if (tsr_done)
                    state_nx = thr_wr ? TX_HOLD : TX_IDLE;
                else if (thr_wr)
                    state_nx = TX_BOTH;
            end
            TX_BOTH:  if (tsr_done) state_nx = TX_HOLD;
        endcase
    end

    always_comb begin
        thre = 1'b0;
        temt = 1'b0;
        unique case (state)
            TX_IDLE:  begin thre = 1'b1; temt = 1'b1; end
            TX_SHIFT: thre = 1'b1;
            TX_HOLD, TX_BOTH: ;
        endcase
    end
endmodule

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker
    import lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              rbr_rd,
    output logic [CHAR_W-1:0] rbr_data,
    input  logic              lsr_rd,
    output logic [7:0]        lsr,
    input  logic              thr_wr,
    input  logic              tsr_load,
    input  logic              tsr_done
);
    rx_entry_t in_entry, head;
    logic      empty, push_acc, pop_acc, overwrite, overflow;
    logic      pe, fe, bi, oe, rxfe, thre, temt;

    assign in_entry = '{err: '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr}, data: rx_data};

    lsr_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk, .rst_n, .fifo_en,
        .push(rx_valid), .push_entry(in_entry), .pop(rbr_rd),
        .head, .empty, .push_acc, .pop_acc, .overwrite, .overflow
    );

    lsr_err_track #(.DEPTH(DEPTH)) u_err (
        .clk, .rst_n, .fifo_en, .lsr_rd, .empty,
        .push_acc, .pop_acc, .overwrite, .overflow,
        .new_err(in_entry.err), .head_err(head.err),
        .pe, .fe, .bi, .oe, .rxfe
    );

    lsr_tx_fsm u_tx (
        .clk, .rst_n, .thr_wr, .tsr_load, .tsr_done, .thre, .temt
    );

    assign rbr_data = head.data;
    assign lsr      = {rxfe, temt, thre, bi, fe, pe, oe, ~empty};
endmodule

// File: rtl/lsr_checker.sv
module lsr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_en,
    input logic       rx_valid,
    input logic       rx_perr,
    input logic       rx_ferr,
    input logic       rx_brk,
    input logic       rbr_rd,
    input logic       lsr_rd,
    input logic       thr_wr,
    input logic [7:0] lsr
);
    // R5
    thr_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !lsr[5]);

    // R6
    temt_needs_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]);

    // R4
    read_clears_errs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !rbr_rd && !rx_valid) |=> (lsr[4:2] == 3'b000));

    // R2
    err_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[4:2] != 3'b000) |-> lsr[0]);

    // R8
    err_push_sets_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_valid && (rx_perr || rx_ferr || rx_brk) && !lsr[0]) |=> lsr[7]);

    // R9
    empty_read_clears_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !rx_valid && !lsr[0]) |=> !lsr[7]);

    // R10
    single_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_valid && lsr[0] && !rbr_rd) |=> (lsr[1] && lsr[0]));
endmodule

bind uart_lsr_tracker lsr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .thr_wr(thr_wr), .lsr(lsr)
);

// File: tb/uart_lsr_tracker_tb.sv
module uart_lsr_tracker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rbr_rd = 1'b0, lsr_rd = 1'b0;
    logic       thr_wr = 1'b0, tsr_load = 1'b0, tsr_done = 1'b0;
    logic [7:0] rbr_data, lsr;

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 0;

    // scoreboard: {brk, ferr, perr, data}
    logic [10:0] sb_q[$];
    bit m_ack = 0, m_rxfe = 0, m_oe = 0, m_h = 0, m_s = 0;

    always #2 clk = ~clk;

    uart_lsr_tracker u_dut (
        .clk, .rst_n, .fifo_en, .rx_valid, .rx_data, .rx_perr, .rx_ferr, .rx_brk,
        .rbr_rd, .rbr_data, .lsr_rd, .lsr, .thr_wr, .tsr_load, .tsr_done
    );

    function automatic logic [7:0] exp_lsr();
        logic [2:0] e;
        e = (sb_q.size() != 0 && !m_ack) ? sb_q[0][10:8] : 3'b000;
        return {fifo_en & m_rxfe, (!m_h && !m_s), !m_h, e[2], e[1], e[0], m_oe, sb_q.size() != 0};
    endfunction

    task automatic model_update();
        bit emp, pop_a, room, push_a, ovw, hchg, nerr;
        int cap, ecnt;
        emp   = (sb_q.size() == 0);
        cap   = fifo_en ? 16 : 1;
        pop_a = rbr_rd && !emp;
        room  = (sb_q.size() < cap) || pop_a;
        push_a = rx_valid && room;
        ovw   = rx_valid && !room && !fifo_en;
        hchg  = pop_a || (push_a && emp) || ovw;
        nerr  = rx_perr || rx_ferr || rx_brk;
        if (rx_valid && !room) m_oe = 1; else if (lsr_rd) m_oe = 0;
        if (hchg) m_ack = 0; else if (lsr_rd) m_ack = 1;
        if (ovw) sb_q[0] = {rx_brk, rx_ferr, rx_perr, rx_data};
        else begin
            if (pop_a) void'(sb_q.pop_front());
            if (push_a) sb_q.push_back({rx_brk, rx_ferr, rx_perr, rx_data});
        end
        ecnt = 0;
        foreach (sb_q[i]) if (sb_q[i][10:8] != 0) ecnt++;
        if ((push_a || ovw) && nerr) m_rxfe = 1;
        else if (lsr_rd) m_rxfe = (ecnt != 0);
        // transmit side
        if (!m_s) begin
            if (m_h && tsr_load) begin m_s = 1; m_h = thr_wr; end
            else if (thr_wr) m_h = 1;
        end else begin
            if (tsr_done) begin m_s = 0; m_h = m_h | thr_wr; end
            else if (thr_wr) m_h = 1;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
        rbr_rd = 0; lsr_rd = 0; thr_wr = 0; tsr_load = 0; tsr_done = 0;
    endtask

    task automatic chk_lsr(string req);
        logic [7:0] e;
        e = exp_lsr();
        n_cmp++;
        if (lsr !== e) begin
            n_bad++;
            $display("FAIL %s: lsr actual %02h expected %02h", req, lsr, e);
        end
    endtask

    task automatic push(logic [7:0] d, logic [2:0] err);
        rx_valid = 1; rx_data = d; {rx_brk, rx_ferr, rx_perr} = err;
        tick();
    endtask

    // monitor side of the scoreboard: compare head, then pop it
    task automatic pop_chk(string req);
        if (sb_q.size() != 0) begin
            n_cmp++;
            if (rbr_data !== sb_q[0][7:0]) begin
                n_bad++;
                $display("FAIL %s: rbr_data actual %02h expected %02h", req, rbr_data, sb_q[0][7:0]);
            end
        end
        rbr_rd = 1;
        tick();
    endtask

    task automatic rd_lsr(string req);
        chk_lsr(req);
        lsr_rd = 1;
        tick();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_lsr("R1 reset");

        // transmit side
        thr_wr = 1; tick(); chk_lsr("R5 write clears thre");
        chk_lsr("R6 temt low with holding full");
        tsr_load = 1; tick(); chk_lsr("R7 load moves to shift");
        tsr_done = 1; tick(); chk_lsr("R6 idle after done");
        tsr_done = 1; tick(); chk_lsr("R7 done ignored in idle");
        thr_wr = 1; tick();
        tsr_load = 1; thr_wr = 1; tick(); chk_lsr("R7 load with write gives both");
        tsr_load = 1; tick(); chk_lsr("R7 load ignored in both");
        tsr_done = 1; tick(); chk_lsr("R7 both to hold");
        tsr_load = 1; tick(); thr_wr = 1; tick(); chk_lsr("R7 shift to both");
        tsr_done = 1; tick(); tsr_load = 1; tick();
        tsr_done = 1; thr_wr = 1; tick(); chk_lsr("R7 done with write gives hold");
        tsr_load = 1; tick(); tsr_done = 1; tick(); chk_lsr("R5 back to idle");

        // receive: head-relative flags and summary
        push(8'hA1, 3'b000); chk_lsr("R2 data ready");
        push(8'hB2, 3'b001); chk_lsr("R3 head clean, R8 summary set");
        pop_chk("R2 head A1"); chk_lsr("R3 parity of new head");
        rd_lsr("R4 before read"); chk_lsr("R4 parity cleared, R9 summary kept");
        pop_chk("R2 head B2"); chk_lsr("R9 summary before read");
        rd_lsr("R9 read"); chk_lsr("R9 summary cleared");
        pop_chk("R2 pop on empty"); chk_lsr("R2 empty pop ignored");

        push(8'hC3, 3'b010); push(8'hD4, 3'b100);
        chk_lsr("R3 framing head");
        rd_lsr("R4 framing read"); chk_lsr("R4 framing cleared");
        pop_chk("R2 head C3"); chk_lsr("R3 break of new head");
        rd_lsr("R9 one errored left"); chk_lsr("R9 summary stays");
        pop_chk("R2 head D4"); rd_lsr("R9 drain"); chk_lsr("R9 cleared");

        // fill and overrun
        for (int i = 0; i < 16; i++) push(8'(8'h10 + i), 3'b000);
        chk_lsr("R11 full no overrun");
        push(8'hEE, 3'b000); chk_lsr("R11 overrun set");
        rd_lsr("R11 read"); chk_lsr("R11 overrun cleared");
        for (int i = 0; i < 16; i++) pop_chk("R11 drain order");
        chk_lsr("R2 empty after drain");

        // single-register mode
        fifo_en = 0; @(negedge clk);
        push(8'h55, 3'b001); chk_lsr("R10 summary masked");
        push(8'h66, 3'b000); chk_lsr("R10 overwrite overrun");
        n_cmp++;
        if (rbr_data !== 8'h66) begin
            n_bad++;
            $display("FAIL R10: rbr_data actual %02h expected 66", rbr_data);
        end
        rd_lsr("R10 read"); pop_chk("R10 pop");
        rd_lsr("R10 clear"); chk_lsr("R10 empty");
        fifo_en = 1; @(negedge clk);
        chk_lsr("R1 final");
        finish_run();
    end
endmodule